// File: doc/BRIEF.md
# Octal Inverting Latched Bus Transceiver

This block moves 8-bit words between two buses, side A and side B. Each direction (A to B, B to A) owns a bank of storage latches and three active-low controls: a direction enable, a capture enable and a drive enable. A bank follows its input while both its direction enable and its capture enable are low. It keeps its last value when either goes high. The bank's contents reach the far side inverted, and only while that side is driven.

The bidirectional pins are split into an input vector, an output vector and a drive flag per side, so the pad ring can build the real three-state buffers. The latches are modelled on the block clock. A bank is open when its enables are low. In that state the output tracks the input within the same cycle, and every clock edge refreshes the held word. Once the bank closes, the output shows the word captured at the last edge at which the bank was open. Both directions may drive at the same time; the block does not arbitrate.

Top module: `oct_inv_latch_xcvr`

## Requirements
- R1: While `ab_ce_n` is high, `b_oe` is 0 and `b_out` is all zeros, and the A-to-B bank keeps its contents whatever `ab_le_n`, `ab_oe_n` and `a_in` do.
- R2: While `ab_ce_n` and `ab_le_n` are both low, the A-to-B bank is transparent: with the drive enabled, `b_out` equals the bitwise inverse of `a_in` in the same cycle.
- R3: After `ab_le_n` goes high with `ab_ce_n` low, the bank holds the `a_in` word sampled at the last clock edge at which it was open, and `b_out` shows its inverse while `a_in` changes.
- R4: `b_oe` is 1 exactly when `ab_ce_n` and `ab_oe_n` are both low; whenever `b_oe` is 0, `b_out` is all zeros.
- R5: If `ab_ce_n` rises while `ab_le_n` stays low, transparency ends, and the word held is the one from the last open edge.
- R6: Toggling `ab_oe_n` while the bank holds a value does not change that value: re-enabling the drive shows the same inverted word.
- R7: The B-to-A direction obeys R1 to R6 with `ba_ce_n`, `ba_le_n`, `ba_oe_n`, `b_in`, `a_out` and `a_oe`, independently of the A-to-B controls.
- R8: Both directions may be transparent and driving at once, each showing the inverse of its own input with no interaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; latch refresh edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears both banks |
| a_in | input | 8 | Word arriving from side A |
| a_out | output | 8 | Inverted B-to-A bank contents toward side A (zero when not driven) |
| a_oe | output | 1 | Side A drive flag |
| b_in | input | 8 | Word arriving from side B |
| b_out | output | 8 | Inverted A-to-B bank contents toward side B (zero when not driven) |
| b_oe | output | 1 | Side B drive flag |
| ab_ce_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B capture enable, active low |
| ab_oe_n | input | 1 | Side B drive enable, active low |
| ba_ce_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A capture enable, active low |
| ba_oe_n | input | 1 | Side A drive enable, active low |

## Verification
The data patterns are all zeros, all ones, alternating bits and mixed nibbles. Passing them while transparent shows that every bit is inverted on its own, and shows that no bit lane is stuck or swapped. Changing the input after a capture shows whether a bank holds or still follows. Two routes close a bank: the capture enable rising, and the direction enable rising. Running both routes checks that either one stops transparency. Drive-enable toggles over a held word check that the drive path and the storage are kept apart. Running both directions together with different words shows that neither bank leaks into the other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;

  typedef struct packed {
    logic ce_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             le_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic             open_q;
  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_nxt;
  logic             armed_q;

  always_comb open_q = ~ce_n & ~le_n;

  always_comb begin
    store_nxt = store_q;
    if (open_q) store_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= store_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_comb q = open_q ? d : store_q;

  // R3: a closed bank keeps its output from one cycle to the next
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !open_q) |=> (open_q || $stable(q)));

  // R5: direction enable rising over a low capture enable freezes the last open word
  a_r5_ce_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ce_n && !le_n && $past(!ce_n && !le_n)) |-> (q == $past(d)));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             ce_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] y,
  output logic             y_oe
);
  logic drive_en;

  always_comb drive_en = ~ce_n & ~oe_n;

  always_comb begin
    y_oe = drive_en;
    y    = '0;
    if (drive_en) y = ~q;
  end
endmodule

// File: rtl/oct_inv_latch_xcvr.sv
module oct_inv_latch_xcvr #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_ce_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_ce_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n
);
  import xcvr_pkg::*;

  dir_ctrl_t        ctrl   [NUM_DIR];
  logic [WIDTH-1:0] din    [NUM_DIR];
  logic [WIDTH-1:0] held   [NUM_DIR];
  logic [WIDTH-1:0] dout   [NUM_DIR];
  logic             dout_oe[NUM_DIR];

  always_comb begin
    ctrl[DIR_AB] = '{ce_n: ab_ce_n, le_n: ab_le_n, oe_n: ab_oe_n};
    ctrl[DIR_BA] = '{ce_n: ba_ce_n, le_n: ba_le_n, oe_n: ba_oe_n};
    din[DIR_AB]  = a_in;
    din[DIR_BA]  = b_in;
  end

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    xcvr_latch_bank #(.WIDTH(WIDTH)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .ce_n (ctrl[g].ce_n),
      .le_n (ctrl[g].le_n),
      .d    (din[g]),
      .q    (held[g])
    );

    xcvr_drive #(.WIDTH(WIDTH)) u_drive (
      .ce_n(ctrl[g].ce_n),
      .oe_n(ctrl[g].oe_n),
      .q   (held[g]),
      .y   (dout[g]),
      .y_oe(dout_oe[g])
    );

    // R2: a driven side always shows the bitwise inverse of its bank
    a_r2_inverted: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe[g] |-> ((dout[g] ^ held[g]) == {WIDTH{1'b1}}));

    // R4: an undriven side rests at zero
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe[g] |-> (dout[g] == '0));

    // R1: a high direction enable blocks the drive
    a_r1_ce_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[g].ce_n |-> !dout_oe[g]);
  end

  always_comb begin
    b_out = dout[DIR_AB];
    b_oe  = dout_oe[DIR_AB];
    a_out = dout[DIR_BA];
    a_oe  = dout_oe[DIR_BA];
  end

  // R7: side A drive flag follows only the B-to-A controls
  a_r7_ba_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_ce_n || ba_oe_n) |-> !a_oe);
endmodule

// File: tb/oct_inv_latch_xcvr_bench.sv
`timescale 1ns/1ps
module oct_inv_latch_xcvr_bench;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_ce_n, ab_le_n, ab_oe_n, ba_ce_n, ba_le_n, ba_oe_n;

  int n_vec;
  int n_bad;
  logic [W-1:0] m_ab, m_ba;

  oct_inv_latch_xcvr #(.WIDTH(W)) u_oct_inv_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_side(input string tag, input string side,
                            input logic [W-1:0] got, input logic got_oe,
                            input logic [W-1:0] exp, input logic exp_oe);
    n_vec++;
    if (got !== exp || got_oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s side %s: got out=%h oe=%b, expected out=%h oe=%b",
               tag, side, got, got_oe, exp, exp_oe);
    end
  endtask

  // one cycle: drive at negedge, compare mid-low-phase, update model at posedge
  task automatic step(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic abce, input logic able, input logic aboe,
                      input logic bace, input logic bale, input logic baoe);
    logic ab_open, ba_open, eb, ea;
    logic [W-1:0] qab, qba;
    @(negedge clk);
    a_in = a; b_in = b;
    ab_ce_n = abce; ab_le_n = able; ab_oe_n = aboe;
    ba_ce_n = bace; ba_le_n = bale; ba_oe_n = baoe;
    #5;
    ab_open = !abce && !able;
    ba_open = !bace && !bale;
    qab = ab_open ? a : m_ab;
    qba = ba_open ? b : m_ba;
    eb = !abce && !aboe;
    ea = !bace && !baoe;
    check_side(tag, "B", b_out, b_oe, eb ? ~qab : '0, eb);
    check_side(tag, "A", a_out, a_oe, ea ? ~qba : '0, ea);
    @(posedge clk);
    if (rst_n) begin
      if (ab_open) m_ab = a;
      if (ba_open) m_ba = b;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0; n_bad = 0; m_ab = '0; m_ba = '0;
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_ce_n = 1; ab_le_n = 1; ab_oe_n = 1;
    ba_ce_n = 1; ba_le_n = 1; ba_oe_n = 1;
    // reset state: both sides idle (R4)
    step("R4 reset", 8'h12, 8'h34, 1,1,1, 1,1,1);
    step("R4 reset", 8'hFF, 8'hFF, 1,0,0, 1,0,0);
    @(negedge clk); rst_n = 1'b1;

    // R2: transparent A to B with several patterns
    step("R2", 8'h00, 8'h00, 0,0,0, 1,1,1);
    step("R2", 8'hFF, 8'h00, 0,0,0, 1,1,1);
    step("R2", 8'hA5, 8'h00, 0,0,0, 1,1,1);
    step("R2", 8'h3C, 8'h00, 0,0,0, 1,1,1);
    // R3: capture enable high, input moves, held word stays
    step("R3", 8'h3C, 8'h00, 0,1,0, 1,1,1);
    step("R3", 8'hC7, 8'h00, 0,1,0, 1,1,1);
    step("R3", 8'h01, 8'h00, 0,1,0, 1,1,1);
    // R6 and R4: drive toggles over a held word
    step("R6 R4", 8'h55, 8'h00, 0,1,1, 1,1,1);
    step("R6", 8'hAA, 8'h00, 0,1,0, 1,1,1);
    step("R6 R4", 8'h0F, 8'h00, 0,1,1, 1,1,1);
    step("R6", 8'hF0, 8'h00, 0,1,0, 1,1,1);
    // R1: direction enable high hides output, ignores other controls
    step("R1", 8'h99, 8'h00, 1,0,0, 1,1,1);
    step("R1", 8'h66, 8'h00, 1,0,0, 1,1,1);
    step("R1", 8'h66, 8'h00, 0,1,0, 1,1,1);
    // R5: direction enable rises while capture enable stays low
    step("R5", 8'h5A, 8'h00, 0,0,0, 1,1,1);
    step("R5", 8'h11, 8'h00, 1,0,0, 1,1,1);
    step("R5", 8'h22, 8'h00, 1,0,1, 1,1,1);
    step("R5", 8'h33, 8'h00, 0,1,0, 1,1,1);

    // R7: B to A direction, same sequence shape
    step("R7", 8'h00, 8'h00, 1,1,1, 0,0,0);
    step("R7", 8'h00, 8'hFF, 1,1,1, 0,0,0);
    step("R7", 8'h00, 8'h96, 1,1,1, 0,0,0);
    step("R7", 8'h00, 8'h4B, 1,1,1, 0,1,0);
    step("R7", 8'h00, 8'hE1, 1,1,1, 0,1,1);
    step("R7", 8'h00, 8'h7E, 1,1,1, 0,1,0);
    step("R7", 8'h00, 8'h81, 1,1,1, 1,0,0);
    step("R7", 8'h00, 8'h18, 1,1,1, 0,1,0);
    step("R7", 8'h00, 8'hC3, 1,1,1, 0,0,0);
    step("R7", 8'h00, 8'h24, 1,1,1, 1,0,0);
    step("R7", 8'h00, 8'h42, 1,1,1, 0,1,0);

    // R8: both directions transparent and driving together
    step("R8", 8'h12, 8'hED, 0,0,0, 0,0,0);
    step("R8", 8'hA0, 8'h05, 0,0,0, 0,0,0);
    step("R8", 8'h7F, 8'h80, 0,1,0, 0,0,0);
    step("R8", 8'h01, 8'hFE, 0,0,0, 0,1,0);
    step("R8", 8'hC0, 8'h0C, 0,1,0, 0,1,0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule